// File: doc/BRIEF.md
# Stereo Offset Calibration Sequencer

This block removes the DC offset from a stereo stream of signed samples. It watches an active-low power-down input. When calibration is enabled and that input goes high after a low period long enough to qualify, the block starts a calibration run. During the run it averages a fixed number of zero-input samples on each channel and keeps the result as that channel's offset. After the run it subtracts the stored offset from every sample that follows, and it clamps the result to the signed sample range.

While power-down is low or a calibration run is active, the block raises a control that tells the downstream serializer to hold its data line low, and it drives zero on the corrected sample outputs. When the calibration-disable input is high, the stored offsets are not used and samples pass through unchanged. All outputs are registered, so every output shows the inputs of the clock edge before it.

Top module: `offset_cal_seq`

## Requirements
- R1: After a synchronous reset, cal_busy_o, force_low_o and out_valid_o are 0, the sample outputs are 0 and both stored offsets are 0.
- R2: During any cycle in which pd_n_i is low, the next edge sets force_low_o to 1 and both sample outputs to 0.
- R3: With cal_dis_i low, a low period on pd_n_i of more than PD_MIN (default 2) clock edges, followed by pd_n_i high, sets cal_busy_o on the edge where pd_n_i is first sampled high.
- R4: A low period on pd_n_i of PD_MIN edges or fewer does not start a calibration and leaves the stored offsets unchanged.
- R5: While cal_busy_o is 1, the next edge sets force_low_o to 1 and both sample outputs to 0.
- R6: A run ends, and cal_busy_o returns to 0, on the edge that takes the 2^AVG_LOG2-th valid sample (default 1024). Each channel's offset is the floor of that channel's sample sum shifted arithmetically right by AVG_LOG2.
- R7: Outside power-down and calibration, with cal_dis_i low, each valid input sample appears one edge later as sample minus that channel's offset, with out_valid_o copying smp_valid_i.
- R8: A difference above 2^(DATA_W-1)-1 or below -2^(DATA_W-1) is clamped to that limit and does not wrap.
- R9: With cal_dis_i high, samples pass through unchanged and no power-down pulse starts a calibration.
- R10: If pd_n_i goes low during a run, the run is abandoned on that edge (cal_busy_o returns to 0) and the offsets from the previous completed run are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_dis_i | input | 1 | 1 disables calibration and offset subtraction |
| pd_n_i | input | 1 | Active-low power-down; a qualifying low pulse starts calibration |
| smp_valid_i | input | 1 | Strobe for both input samples |
| smp_left_i | input | DATA_W | Left channel sample, two's complement |
| smp_right_i | input | DATA_W | Right channel sample, two's complement |
| cal_busy_o | output | 1 | High while a calibration run is active |
| force_low_o | output | 1 | Tells the serializer to hold its data low |
| out_valid_o | output | 1 | Strobe for corrected samples |
| out_left_o | output | DATA_W | Corrected left sample |
| out_right_o | output | DATA_W | Corrected right sample |

## Verification
The hardest state to reach from the ports is an interrupted run. A run must first be started and then cut short with a power-down pulse short enough not to start a new run, and the bench must then show through the normal output path that the earlier offsets survived. The bench first completes a run with alternating samples whose average is not a whole number, which gives offsets that are easy to recognise. It then starts a second run and feeds it different data. It drops pd_n_i for a single cycle during that run and shows that the corrected outputs still use the first offsets. Saturation in both directions is reached by feeding full-scale samples against offsets of opposite sign.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CAL  = 1'b1
  } cal_state_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/ocs_pulse_qual.sv
// Measures how long the power-down input stays low and flags a qualifying release.
module ocs_pulse_qual #(
  parameter int PD_MIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_i,
  output logic release_ok_o
);
  localparam int CNT_MAX = PD_MIN + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] low_cnt;
  logic             pd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      pd_q    <= 1'b1;
    end else begin
      pd_q <= pd_n_i;
      if (!pd_n_i) begin
        if (low_cnt != CNT_W'(CNT_MAX)) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end
  end

  // first high cycle after a low run longer than PD_MIN edges
  assign release_ok_o = pd_n_i && !pd_q && (low_cnt == CNT_W'(CNT_MAX));
endmodule

// File: rtl/ocs_accum.sv
// Sums one channel's zero-input samples and stores the floor average.
module ocs_accum #(
  parameter int DATA_W   = 20,
  parameter int AVG_LOG2 = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear_i,
  input  logic                     add_i,
  input  logic                     last_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] offset_o
);
  localparam int ACC_W = DATA_W + AVG_LOG2;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_sum;
  logic signed [ACC_W-1:0] avg;

  assign acc_sum = acc + ACC_W'(sample_i);
  assign avg     = acc_sum >>> AVG_LOG2;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      offset_o <= '0;
    end else if (clear_i) begin
      acc <= '0;
    end else if (add_i) begin
      if (last_i) begin
        acc      <= '0;
        offset_o <= avg[DATA_W-1:0];
      end else begin
        acc <= acc_sum;
      end
    end
  end
endmodule

// File: rtl/ocs_corrector.sv
// Registered subtract-and-clamp stage for one channel.
module ocs_corrector #(
  parameter int DATA_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     force_i,
  input  logic                     bypass_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [DATA_W-1:0] offset_i,
  output logic signed [DATA_W-1:0] data_o
);
  localparam int DIFF_W = DATA_W + 1;
  localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DIFF_W-1:0] diff;
  logic signed [DATA_W-1:0] clamped;

  assign diff = DIFF_W'(sample_i) - DIFF_W'(offset_i);

  always_comb begin
    if (diff[DIFF_W-1] != diff[DIFF_W-2])
      clamped = diff[DIFF_W-1] ? NEG_LIM : POS_LIM;
    else
      clamped = diff[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           data_o <= '0;
    else if (force_i)  data_o <= '0;
    else if (bypass_i) data_o <= sample_i;
    else               data_o <= clamped;
  end
endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq #(
  parameter int DATA_W   = 20,
  parameter int AVG_LOG2 = 10,
  parameter int PD_MIN   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_dis_i,
  input  logic              pd_n_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_left_i,
  input  logic [DATA_W-1:0] smp_right_i,
  output logic              cal_busy_o,
  output logic              force_low_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_left_o,
  output logic [DATA_W-1:0] out_right_o
);
  import ocs_pkg::*;

  localparam int CNT_W = AVG_LOG2;

  cal_state_e       state;
  logic [CNT_W-1:0] smp_cnt;
  logic             release_ok;
  logic             cal_go;
  logic             cal_add;
  logic             cal_last;
  logic             force_now;

  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_off [NUM_CH];
  logic signed [DATA_W-1:0] ch_out [NUM_CH];

  ocs_pulse_qual #(.PD_MIN(PD_MIN)) u_qual (
    .clk          (clk),
    .rst          (rst),
    .pd_n_i       (pd_n_i),
    .release_ok_o (release_ok)
  );

  assign cal_go    = (state == ST_IDLE) && release_ok && !cal_dis_i;
  assign cal_add   = (state == ST_CAL) && pd_n_i && smp_valid_i;
  assign cal_last  = (smp_cnt == {CNT_W{1'b1}});
  assign force_now = !pd_n_i || (state == ST_CAL) || cal_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      smp_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cal_go) begin
          state   <= ST_CAL;
          smp_cnt <= '0;
        end
        ST_CAL: begin
          if (!pd_n_i) begin
            state <= ST_IDLE;
          end else if (smp_valid_i) begin
            smp_cnt <= smp_cnt + 1'b1;
            if (cal_last) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cal_busy_o = (state == ST_CAL);

  assign ch_in[0] = smp_left_i;
  assign ch_in[1] = smp_right_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ocs_accum #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .clear_i  (cal_go),
      .add_i    (cal_add),
      .last_i   (cal_last),
      .sample_i (ch_in[g]),
      .offset_o (ch_off[g])
    );

    ocs_corrector #(.DATA_W(DATA_W)) u_cor (
      .clk      (clk),
      .rst      (rst),
      .force_i  (force_now),
      .bypass_i (cal_dis_i),
      .sample_i (ch_in[g]),
      .offset_i (ch_off[g]),
      .data_o   (ch_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_low_o <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      force_low_o <= force_now;
      out_valid_o <= smp_valid_i;
    end
  end

  assign out_left_o  = ch_out[0];
  assign out_right_o = ch_out[1];
endmodule

// File: rtl/ocs_checker.sv
module ocs_checker #(
  parameter int DATA_W   = 20,
  parameter int AVG_LOG2 = 10,
  parameter int PD_MIN   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cal_dis_i,
  input logic              pd_n_i,
  input logic              smp_valid_i,
  input logic              cal_busy_o,
  input logic              force_low_o,
  input logic [DATA_W-1:0] out_left_o,
  input logic [DATA_W-1:0] out_right_o
);
  localparam int VC_W = AVG_LOG2 + 1;
  localparam logic [VC_W-1:0] VC_FULL = VC_W'(1) << AVG_LOG2;

  logic [15:0]     lo_cnt;
  logic [VC_W-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      vcnt   <= '0;
    end else begin
      if (pd_n_i) lo_cnt <= '0;
      else if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
      if (!cal_busy_o) vcnt <= '0;
      else if (smp_valid_i && pd_n_i) vcnt <= vcnt + 1'b1;
    end
  end

  // R2
  p_pd_forces_r2: assert property (@(posedge clk) disable iff (rst)
    !pd_n_i |=> (force_low_o && out_left_o == '0 && out_right_o == '0));

  // R3 / R4
  p_start_qualified_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy_o) |-> ($past(pd_n_i) && $past(lo_cnt) > 16'(PD_MIN)));

  // R5
  p_busy_forces_r5: assert property (@(posedge clk) disable iff (rst)
    cal_busy_o |=> (force_low_o && out_left_o == '0 && out_right_o == '0));

  // R6
  p_run_length_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(cal_busy_o) && $past(pd_n_i)) |-> (vcnt == VC_FULL));

  // R9
  p_dis_no_start_r9: assert property (@(posedge clk) disable iff (rst)
    (cal_dis_i && !cal_busy_o) |=> !cal_busy_o);

  // R10
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (cal_busy_o && !pd_n_i) |=> !cal_busy_o);
endmodule

bind offset_cal_seq ocs_checker #(
  .DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2), .PD_MIN(PD_MIN)
) u_ocs_checker (
  .clk         (clk),
  .rst         (rst),
  .cal_dis_i   (cal_dis_i),
  .pd_n_i      (pd_n_i),
  .smp_valid_i (smp_valid_i),
  .cal_busy_o  (cal_busy_o),
  .force_low_o (force_low_o),
  .out_left_o  (out_left_o),
  .out_right_o (out_right_o)
);

// File: tb/test_offset_cal_seq.sv
module test_offset_cal_seq;
  localparam int DW = 20;
  localparam int NAVG = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_dis = 1'b0;
  logic pd_n = 1'b1;
  logic valid = 1'b0;
  logic [DW-1:0] left = '0;
  logic [DW-1:0] right = '0;
  logic cal_busy, force_low, out_valid;
  logic [DW-1:0] out_l, out_r;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  offset_cal_seq i_offset_cal_seq (
    .clk(clk), .rst(rst), .cal_dis_i(cal_dis), .pd_n_i(pd_n),
    .smp_valid_i(valid), .smp_left_i(left), .smp_right_i(right),
    .cal_busy_o(cal_busy), .force_low_o(force_low), .out_valid_o(out_valid),
    .out_left_o(out_l), .out_right_o(out_r)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs, sample just after the capturing edge
  task automatic cyc(input logic v, input int l, input int r);
    @(negedge clk);
    valid = v; left = DW'(l); right = DW'(r);
    @(posedge clk);
    #1;
  endtask

  function automatic int sx(input logic [DW-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) cyc(0, 0, 0);
    check("R1 busy", int'(cal_busy), 0);
    check("R1 force", int'(force_low), 0);
    check("R1 valid", int'(out_valid), 0);
    check("R1 data", sx(out_l) | sx(out_r), 0);
    rst = 1'b0;
    cyc(1, 321, -45);
    check("R1 zero offset left", sx(out_l), 321);
    check("R1 zero offset right", sx(out_r), -45);
  endtask

  task automatic t_powerdown;
    cal_dis = 1'b1;
    pd_n = 1'b0;
    for (int i = 0; i < 5; i++) cyc(1, 500, -500);
    check("R2 force", int'(force_low), 1);
    check("R2 data", sx(out_l) | sx(out_r), 0);
    pd_n = 1'b1;
    cyc(1, 77, 88);
    check("R9 no start", int'(cal_busy), 0);
    check("R9 pass left", sx(out_l), 77);
    check("R2 force released", int'(force_low), 0);
    cal_dis = 1'b0;
  endtask

  task automatic t_short_pulse;
    pd_n = 1'b0;
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    pd_n = 1'b1;
    cyc(0, 0, 0);
    check("R4 no start", int'(cal_busy), 0);
    cyc(1, 1234, -99);
    check("R4 busy still low", int'(cal_busy), 0);
    check("R4 offset unchanged", sx(out_l), 1234);
  endtask

  task automatic t_calibrate;
    pd_n = 1'b0;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    pd_n = 1'b1;
    cyc(0, 0, 0);
    check("R3 busy set", int'(cal_busy), 1);
    check("R5 force at start", int'(force_low), 1);
    for (int i = 0; i < NAVG; i++) begin
      cyc(1, (i % 2 == 1) ? 103 : 100, -7);
      if (i == NAVG / 2) check("R5 data low", sx(out_l), 0);
      if (i == NAVG - 2) check("R6 busy before last", int'(cal_busy), 1);
    end
    check("R6 busy cleared", int'(cal_busy), 0);
    check("R5 force last", int'(force_low), 1);
    cyc(1, 1000, 5);
    check("R7 force off", int'(force_low), 0);
    check("R7 valid", int'(out_valid), 1);
    check("R6 R7 left", sx(out_l), 899);
    check("R6 R7 right", sx(out_r), 12);
    cyc(0, 0, 0);
    check("R7 valid low", int'(out_valid), 0);
  endtask

  task automatic t_saturate;
    cyc(1, -524288, 524287);
    check("R8 negative clamp", sx(out_l), -524288);
    check("R8 positive clamp", sx(out_r), 524287);
    cyc(1, -524187, 524280);
    check("R8 exact low", sx(out_l), -524288);
    check("R8 exact high", sx(out_r), 524287);
  endtask

  task automatic t_disable;
    cal_dis = 1'b1;
    cyc(1, 1000, 5);
    check("R9 bypass left", sx(out_l), 1000);
    check("R9 bypass right", sx(out_r), 5);
    pd_n = 1'b0;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);
    pd_n = 1'b1;
    cyc(0, 0, 0);
    check("R9 long pulse ignored", int'(cal_busy), 0);
    cal_dis = 1'b0;
    cyc(1, 1000, 5);
    check("R9 offsets kept", sx(out_l), 899);
  endtask

  task automatic t_abort;
    pd_n = 1'b0;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    pd_n = 1'b1;
    cyc(0, 0, 0);
    check("R10 run started", int'(cal_busy), 1);
    for (int i = 0; i < 10; i++) cyc(1, 5000, 5000);
    pd_n = 1'b0;
    cyc(1, 5000, 5000);
    check("R10 aborted", int'(cal_busy), 0);
    pd_n = 1'b1;
    cyc(0, 0, 0);
    check("R10 no restart", int'(cal_busy), 0);
    cyc(1, 1000, 5);
    check("R10 left kept", sx(out_l), 899);
    check("R10 right kept", sx(out_r), 12);
  endtask

  initial begin
    t_reset();
    t_powerdown();
    t_short_pulse();
    t_calibrate();
    t_saturate();
    t_disable();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule